// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block gathers single-cycle event pulses from the datapath of a network-style controller into sticky cause bits. It gates them with an enable mask and drives one level interrupt pin. Software reaches it over a plain 32-bit register strobe. The mask is never written as a whole word: one register turns bits on and a second register turns bits off. Software can therefore change one source without reading the mask first.

Every change of the interrupt level also produces a message for the host interrupt controller: assert (1) or deassert (0). Messages leave in order over a valid/ready stream. While `msg_ready` is low, the head message is held with stable data and newer messages queue behind it. A later assert can therefore never pass a deassert that is still waiting. If the queue is full, the unit remembers the last level it queued and enqueues a message once there is room and the level still differs.

Top module: `intr_cause_mask`

## Requirements
- R1: After reset the mask is 0, all cause bits are 0, `irq_out` is 0 and `msg_valid` is 0.
- R2: A write to offset 0x08 sets every mask bit written as 1 and leaves every bit written as 0 unchanged. A read of 0x08 returns the current mask.
- R3: A write to offset 0x0C clears every mask bit written as 1 and leaves bits written as 0 unchanged.
- R4: A one-cycle pulse on `evt_pulse[i]` sets cause bit i from the next cycle on. A write of ones to offset 0x04 also sets those cause bits. A read of 0x00 returns the cause bits. Implemented sources are bit 0 (descriptor written back), bit 1 (transmit queue empty), bit 2 (link change), bits 14:13 (general inputs), bit 15 (descriptor low threshold) and bit 16 (small receive packet).
- R5: A read of offset 0x00 returns the cause bits and clears them at that clock edge.
- R6: An event pulse in the same cycle as a cause read wins: its cause bit is set after that edge.
- R7: `irq_out` is 1 exactly when some cause bit and its mask bit are both 1.
- R8: Each change of `irq_out` queues one message: `msg_assert`=1 for a rise and 0 for a fall. It is visible on `msg_valid` one cycle after the level change.
- R9: Messages leave in the order they were queued. While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and `msg_assert` is stable.
- R10: Bits 3 to 12 and 17 to 31 read as 0 in every register, and writes to them have no effect.
- R11: A write of all ones to 0x0C drops `irq_out` to 0 at that edge and queues a deassert message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_en | input | 1 | Register access strobe for this cycle |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 4 | Byte offset (0x00, 0x04, 0x08, 0x0C) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| evt_pulse | input | 17 | Event pulses, one bit per source |
| irq_out | output | 1 | Level interrupt |
| msg_valid | output | 1 | A message is available |
| msg_ready | input | 1 | The receiver accepts the message |
| msg_assert | output | 1 | 1 for an assert message, 0 for a deassert message |

## Verification
The hardest case to reach is an assert queued behind a deassert that has not yet left. Reaching it needs the level to fall and rise again while the receiver stalls. The stimulus holds `msg_ready` low and latches a masked event. It then clears the whole mask and sets it again while the cause is still pending. This leaves assert, deassert and assert waiting in the queue. The bench checks that the head is held steady, then drains the three messages one at a time and checks their order. A second targeted case places an event pulse in the same cycle as a cause read.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_CSET  = 2'd1,
    SEL_MSET  = 2'd2,
    SEL_MCLR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intr_cause_bank.sv
module intr_cause_bank #(
  parameter int unsigned          NUM_SRC    = 17,
  parameter logic [NUM_SRC-1:0]   VALID_MASK = 17'h1E007
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               set_en,
  input  logic [NUM_SRC-1:0] set_bits,
  input  logic               rd_clr,
  output logic [NUM_SRC-1:0] cause_q
);
  logic [NUM_SRC-1:0] kept;
  logic [NUM_SRC-1:0] added;

  // a read clears what it returned; new pulses land on top of that
  assign kept  = rd_clr ? '0 : cause_q;
  assign added = evt | (set_en ? set_bits : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (kept | added) & VALID_MASK;
  end
endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg #(
  parameter int unsigned        NUM_SRC    = 17,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 17'h1E007
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] bits,
  output logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] nxt;

  always_comb begin
    nxt = mask_q;
    if (set_en) nxt = nxt | bits;
    if (clr_en) nxt = nxt & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= nxt & VALID_MASK;
  end
endmodule

// File: rtl/intr_msg_fifo.sv
module intr_msg_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned MSG_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [MSG_W-1:0] push_data,
  output logic             full,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MSG_W-1:0] out_data
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [MSG_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/intr_cause_mask.sv
module intr_cause_mask #(
  parameter int unsigned        NUM_SRC    = 17,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 17'h1E007,
  parameter int unsigned        FIFO_DEPTH = 4,
  parameter int unsigned        ADDR_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_en,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NUM_SRC-1:0]     evt_pulse,
  output logic                   irq_out,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic                   msg_assert
);
  import intr_pkg::*;

  localparam int unsigned PAD = REG_W - NUM_SRC;

  logic               hit;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] cause_q, mask_q;
  logic               lvl_now, lvl_q, fifo_full, push;
  logic [0:0]         head;
  logic               unused_wr_hi;

  assign sel   = reg_sel_e'(reg_addr[3:2]);
  assign hit   = reg_en && (reg_addr[1:0] == 2'b00) && ((reg_addr >> 4) == '0);
  assign wbits = reg_wdata[NUM_SRC-1:0];
  assign unused_wr_hi = ^reg_wdata[REG_W-1:NUM_SRC];

  intr_cause_bank #(.NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .set_en   (hit && reg_we && sel == SEL_CSET),
    .set_bits (wbits),
    .rd_clr   (hit && !reg_we && sel == SEL_CAUSE),
    .cause_q  (cause_q)
  );

  intr_mask_reg #(.NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (hit && reg_we && sel == SEL_MSET),
    .clr_en (hit && reg_we && sel == SEL_MCLR),
    .bits   (wbits),
    .mask_q (mask_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit && !reg_we) begin
      unique case (sel)
        SEL_CAUSE: reg_rdata = {{PAD{1'b0}}, cause_q};
        SEL_MSET:  reg_rdata = {{PAD{1'b0}}, mask_q};
        default:   reg_rdata = '0;
      endcase
    end
  end

  // level and message generation; lvl_q is the last level handed to the queue
  assign lvl_now = |(cause_q & mask_q);
  assign irq_out = lvl_now;
  assign push    = (lvl_now != lvl_q) && !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl_q <= 1'b0;
    else if (push) lvl_q <= lvl_now;
  end

  intr_msg_fifo #(.DEPTH(FIFO_DEPTH), .MSG_W(1)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (lvl_now),
    .full      (fifo_full),
    .out_valid (msg_valid),
    .out_ready (msg_ready),
    .out_data  (head)
  );

  assign msg_assert = head[0];
endmodule

// File: rtl/intr_cause_mask_chk.sv
module intr_cause_mask_chk #(
  parameter int unsigned        NUM_SRC    = 17,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 17'h1E007,
  parameter int unsigned        ADDR_W     = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_en,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic               irq_out,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic               msg_assert,
  input logic [NUM_SRC-1:0] mask_q
);
  logic mset_wr, mclr_wr;
  assign mset_wr = reg_en && reg_we && reg_addr == ADDR_W'(8);
  assign mclr_wr = reg_en && reg_we && reg_addr == ADDR_W'(12);

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mset_wr |=> ((mask_q & $past(reg_wdata[NUM_SRC-1:0] & VALID_MASK))
                 == $past(reg_wdata[NUM_SRC-1:0] & VALID_MASK)));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_wr |=> ((mask_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

  assert_evt_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_pulse & mask_q & VALID_MASK)) && !mclr_wr) |=> irq_out);

  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_assert)));

  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we) |-> (reg_rdata[31:NUM_SRC] == '0
                             && (reg_rdata[NUM_SRC-1:0] & ~VALID_MASK) == '0));

  assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr_wr && reg_wdata == 32'hFFFF_FFFF) |=> !irq_out);
endmodule

bind intr_cause_mask intr_cause_mask_chk #(
  .NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/intr_cause_mask_bench.sv
module intr_cause_mask_bench;
  localparam int unsigned NS = 17;
  localparam logic [31:0] IMPL = 32'h0001_E007;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NS-1:0] evt_pulse = '0;
  logic          irq_out, msg_valid, msg_assert;
  logic          msg_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_cause_mask u_intr_cause_mask (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .irq_out(irq_out), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_assert(msg_assert)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic pop_expect(input string req, input logic exp);
    @(negedge clk);
    check({req, " valid"}, {31'd0, msg_valid}, 32'd1);
    check({req, " kind"}, {31'd0, msg_assert}, {31'd0, exp});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    check("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
    rd(4'h8, d); check("R1 mask", d, 32'd0);
    rd(4'h0, d); check("R1 cause", d, 32'd0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(4'h8, 32'h5);           rd(4'h8, d); check("R2 set", d, 32'h5);
    wr(4'h8, 32'h0);           rd(4'h8, d); check("R2 zero keeps", d, 32'h5);
    wr(4'hC, 32'h1);           rd(4'h8, d); check("R3 clear bit", d, 32'h4);
    wr(4'hC, 32'h0);           rd(4'h8, d); check("R3 zero keeps", d, 32'h4);
    wr(4'hC, 32'hFFFF_FFFF);   rd(4'h8, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_rsvd;
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF);   rd(4'h8, d); check("R10 mask bits", d, IMPL);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    check("R7 unmasked irq", {31'd0, irq_out}, 32'd0);
    rd(4'h0, d); check("R10 cause bits", d, IMPL);
    rd(4'h0, d); check("R5 cleared", d, 32'd0);
    check("R8 no msg", {31'd0, msg_valid}, 32'd0);
  endtask

  task automatic t_event;
    logic [31:0] d;
    wr(4'h8, 32'h4);
    pulse(17'h4);
    check("R7 irq up", {31'd0, irq_out}, 32'd1);
    pop_expect("R8 assert", 1'b1);
    rd(4'h0, d); check("R4 cause", d, 32'h4);
    check("R5 irq down", {31'd0, irq_out}, 32'd0);
    pop_expect("R8 deassert", 1'b0);
    pulse(17'h1);
    @(negedge clk);
    check("R7 masked src", {31'd0, irq_out}, 32'd0);
    check("R8 masked no msg", {31'd0, msg_valid}, 32'd0);
    rd(4'h0, d); check("R4 bit0", d, 32'h1);
    wr(4'hC, 32'hFFFF_FFFF);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(4'h8, 32'h2);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = 4'h0; evt_pulse = 17'h2;
    #1 check("R6 read before", reg_rdata, 32'h0);
    @(negedge clk);
    reg_en = 1'b0; evt_pulse = '0;
    check("R6 event wins", {31'd0, irq_out}, 32'd1);
    pop_expect("R6 assert", 1'b1);
    rd(4'h0, d); check("R6 cause kept", d, 32'h2);
    pop_expect("R6 deassert", 1'b0);
    wr(4'hC, 32'hFFFF_FFFF);
  endtask

  task automatic t_order;
    logic [31:0] d;
    wr(4'h8, 32'h8000);
    pulse(17'h8000);
    wr(4'hC, 32'hFFFF_FFFF);
    check("R11 irq low", {31'd0, irq_out}, 32'd0);
    wr(4'h8, 32'h8000);
    check("R7 irq back", {31'd0, irq_out}, 32'd1);
    repeat (3) @(negedge clk);
    check("R9 held head", {30'd0, msg_valid, msg_assert}, 32'h3);
    pop_expect("R9 first assert", 1'b1);
    pop_expect("R11 deassert", 1'b0);
    pop_expect("R9 second assert", 1'b1);
    @(negedge clk);
    check("R9 drained", {31'd0, msg_valid}, 32'd0);
    wr(4'hC, 32'hFFFF_FFFF);
    pop_expect("R11 final deassert", 1'b0);
    rd(4'h0, d); check("R4 bit15", d, 32'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_rsvd();
    t_event();
    t_race();
    t_order();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule